// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from a set of on-chip sources and turns them into a single request to the instruction fetch unit. The request comes with a vector number and a vector address. A parameter mask sets the kind of each source.

- **Flagged sources** hold a pending flag. An event sets the flag whatever the enable state is. The flag stays set until the handler is vectored to, or until software writes a one to clear it.
- **Level sources** have no storage. They request only while their condition input is high.

Each source has its own enable bit. A global enable gates all sources.

When the fetch unit acknowledges a request, the block does two things: it clears the winning flag and it drops the global enable. A handler that sets the global enable again allows nesting. A return-from-interrupt strobe sets the global enable again. It also holds off any new request until one main-program instruction has completed. A relocation input moves the vector table from address zero to a parameterised boot-section base. Vector number 0 is reserved for reset, so source `i` uses vector `i+1`, and each vector slot is two words wide.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset all flags, individual enables, the global enable and the hold-off are clear, so `irq_o`, `flags_o` and `gie_o` read 0.
- R2: For a flagged source, `evt_i` high in a cycle sets its bit in `flags_o` from the next cycle on, even with its enable and the global enable off. The bit stays set until it is cleared.
- R3: Writing 1 in a bit of `flag_clr_i` clears that flag in the next cycle. An event arriving in the same cycle wins, and the flag stays set.
- R4: A level source (its `LEVEL_MASK` bit is 1) requests only while its `evt_i` bit is high. Its bit in `flags_o` always reads 0, and a condition that disappears before enabling produces no request.
- R5: `irq_o` is high exactly when the global enable is set, no hold-off is active, and at least one source is both requesting and individually enabled.
- R6: Among enabled requesting sources the lowest index wins. `vec_idx_o` is the winner's index plus one.
- R7: `vec_addr_o` equals base + 2 × `vec_idx_o`, where the base is 0 when `reloc_i` is 0 and `BOOT_BASE` when `reloc_i` is 1.
- R8: When `ack_i` is high while `irq_o` is high, the winning flag and the global enable are both clear in the next cycle.
- R9: `reti_i` sets the global enable and blocks `irq_o`. The block lifts only when `insn_done_i` is seen in a later cycle than `reti_i`. An `insn_done_i` in the same cycle as `reti_i` does not count.
- R10: Setting the global enable with `gie_set_i` after an acceptance lets a pending request raise `irq_o` again (nesting). `gie_clr_i` clears it.
- R11: Several pending flags are served one per acceptance in ascending index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NSRC | Event pulses (flagged) or conditions (level) |
| en_wr_i | input | 1 | Load individual enables |
| en_wdata_i | input | NSRC | Individual enable values |
| flag_clr_i | input | NSRC | Write-one-to-clear for flags |
| gie_set_i | input | 1 | Set global enable |
| gie_clr_i | input | 1 | Clear global enable |
| reti_i | input | 1 | Return-from-interrupt executed |
| insn_done_i | input | 1 | A main-program instruction completed |
| reloc_i | input | 1 | Select boot-section vector base |
| ack_i | input | 1 | Fetch unit takes the vector |
| irq_o | output | 1 | Vector request |
| vec_idx_o | output | IDX_W | Vector number of the winner (0 when idle) |
| vec_addr_o | output | ADDR_W | Vector word address |
| flags_o | output | NSRC | Pending flags |
| gie_o | output | 1 | Global enable state |

## Verification
Each piece of internal state shows at the ports within one cycle.

- A lost or stuck flag shows in `flags_o` on the cycle after the event or clear, and as a wrong `vec_idx_o` once the source is enabled.
- A global enable left set after acceptance shows in `gie_o`, and as a second `irq_o` on the next cycle.
- A hold-off that fails to arm or to release shows as `irq_o` high, or as `irq_o` stuck low, in the cycle after `reti_i` or after `insn_done_i`.
- A wrong base or stride shows directly in `vec_addr_o` while a request is shown.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

   typedef enum logic {
      SRC_FLAGGED = 1'b0,
      SRC_LEVEL   = 1'b1
   } src_kind_e;

   // Words per vector slot; the address generator picks a shift when this is a power of two.
   localparam int unsigned VEC_WORDS = 2;

   function automatic src_kind_e kind_of(input logic [63:0] mask, input int unsigned pos);
      return mask[pos] ? SRC_LEVEL : SRC_FLAGGED;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
   import irq_vec_pkg::*;
#(
   parameter int unsigned     NSRC       = 8,
   parameter logic [63:0]     LEVEL_MASK = 64'h0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] evt_i,
   input  logic [NSRC-1:0] clr_sw_i,
   input  logic [NSRC-1:0] clr_hw_i,
   output logic [NSRC-1:0] flags_o,
   output logic [NSRC-1:0] pend_o
);

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      if (kind_of(LEVEL_MASK, g) == SRC_LEVEL) begin : g_level
         // No storage: the request follows the condition.
         assign flags_o[g] = 1'b0;
         assign pend_o[g]  = evt_i[g];
      end else begin : g_flag
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q <= 1'b0;
            end else if (evt_i[g]) begin
               flag_q <= 1'b1;          // a new event beats any clear
            end else if (clr_sw_i[g] || clr_hw_i[g]) begin
               flag_q <= 1'b0;
            end
         end
         assign flags_o[g] = flag_q;
         assign pend_o[g]  = flag_q;
      end
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned NSRC  = 8,
   parameter int unsigned IDX_W = 4
) (
   input  logic [NSRC-1:0]  req_i,
   output logic             any_o,
   output logic [NSRC-1:0]  grant_o,
   output logic [IDX_W-1:0] idx_o
);

   if (IDX_W < $clog2(NSRC + 1)) begin : g_bad_idx
      $error("irq_prio_pick: IDX_W too narrow for NSRC");
   end

   always_comb begin
      any_o   = |req_i;
      // Isolate the lowest set bit.
      grant_o = req_i & (~req_i + NSRC'(1));
      idx_o   = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i + 1);
      end
   end

endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr
   import irq_vec_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned BOOT_BASE = 32'h3800,
   parameter int unsigned SLOT_W    = VEC_WORDS
) (
   input  logic              reloc_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam logic [ADDR_W-1:0] BOOT_W = ADDR_W'(BOOT_BASE);
   localparam int unsigned       SH     = $clog2(SLOT_W);

   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] offs;

   assign base = reloc_i ? BOOT_W : '0;

   if (is_pow2(SLOT_W)) begin : g_shift
      assign offs = ADDR_W'(idx_i) << SH;
   end else begin : g_mult
      assign offs = ADDR_W'(idx_i) * ADDR_W'(SLOT_W);
   end

   assign addr_o = base + offs;

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
   import irq_vec_pkg::*;
#(
   parameter int unsigned NSRC       = 8,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned BOOT_BASE  = 32'h3800,
   parameter logic [63:0] LEVEL_MASK = 64'h0000_0000_0000_00C0,
   localparam int unsigned IDX_W     = $clog2(NSRC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   evt_i,
   input  logic              en_wr_i,
   input  logic [NSRC-1:0]   en_wdata_i,
   input  logic [NSRC-1:0]   flag_clr_i,
   input  logic              gie_set_i,
   input  logic              gie_clr_i,
   input  logic              reti_i,
   input  logic              insn_done_i,
   input  logic              reloc_i,
   input  logic              ack_i,
   output logic              irq_o,
   output logic [IDX_W-1:0]  vec_idx_o,
   output logic [ADDR_W-1:0] vec_addr_o,
   output logic [NSRC-1:0]   flags_o,
   output logic              gie_o
);

   if (NSRC < 1 || NSRC > 64) begin : g_bad_nsrc
      $error("irq_vec_ctrl: NSRC must be 1..64");
   end
   if (ADDR_W < IDX_W + 1 || ADDR_W > 31) begin : g_bad_addr
      $error("irq_vec_ctrl: ADDR_W out of range");
   end
   if (64'(BOOT_BASE) + 64'(VEC_WORDS) * 64'(NSRC + 1) > (64'd1 << ADDR_W)) begin : g_bad_base
      $error("irq_vec_ctrl: relocated table does not fit ADDR_W");
   end

   logic [NSRC-1:0] en_q;
   logic            gie_q;
   logic            hold_q;
   logic [NSRC-1:0] pend;
   logic [NSRC-1:0] req;
   logic [NSRC-1:0] grant;
   logic [NSRC-1:0] clr_hw;
   logic [IDX_W-1:0] idx;
   logic            any;
   logic            take;

   irq_src_bank #(
      .NSRC       (NSRC),
      .LEVEL_MASK (LEVEL_MASK)
   ) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i),
      .clr_sw_i (flag_clr_i),
      .clr_hw_i (clr_hw),
      .flags_o  (flags_o),
      .pend_o   (pend)
   );

   assign req = pend & en_q;

   irq_prio_pick #(
      .NSRC  (NSRC),
      .IDX_W (IDX_W)
   ) i_pick (
      .req_i   (req),
      .any_o   (any),
      .grant_o (grant),
      .idx_o   (idx)
   );

   irq_vec_addr #(
      .ADDR_W    (ADDR_W),
      .IDX_W     (IDX_W),
      .BOOT_BASE (BOOT_BASE),
      .SLOT_W    (VEC_WORDS)
   ) i_addr (
      .reloc_i (reloc_i),
      .idx_i   (idx),
      .addr_o  (vec_addr_o)
   );

   assign irq_o     = gie_q && !hold_q && any;
   assign take      = irq_o && ack_i;
   assign clr_hw    = take ? grant : '0;
   assign vec_idx_o = idx;
   assign gie_o     = gie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (en_wr_i) begin
         en_q <= en_wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q <= 1'b0;
      end else if (take || gie_clr_i) begin
         gie_q <= 1'b0;
      end else if (gie_set_i || reti_i) begin
         gie_q <= 1'b1;
      end
   end

   // One completed instruction is owed after each return.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
      end else if (reti_i) begin
         hold_q <= 1'b1;
      end else if (insn_done_i) begin
         hold_q <= 1'b0;
      end
   end

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
   parameter int unsigned NSRC       = 8,
   parameter logic [63:0] LEVEL_MASK = 64'h0,
   parameter int unsigned IDX_W      = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NSRC-1:0]  flag_clr_i,
   input logic             reti_i,
   input logic             ack_i,
   input logic             irq_o,
   input logic [IDX_W-1:0] vec_idx_o,
   input logic [NSRC-1:0]  flags_o,
   input logic             gie_o
);

   // R5
   irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> gie_o);

   // R6
   irq_has_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (vec_idx_o != '0));

   // R8
   ack_drops_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && ack_i) |=> !gie_o);

   // R9
   reti_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reti_i |=> !irq_o);

   // R4
   always @(posedge clk) begin
      if (rst_n) begin
         level_no_flag_chk: assert ((flags_o & NSRC'(LEVEL_MASK)) == '0);
      end
   end

   for (genvar g = 0; g < NSRC; g++) begin : g_hold
      if (!LEVEL_MASK[g]) begin : g_flag
         // R2
         flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[g] && !flag_clr_i[g] && !(irq_o && ack_i && vec_idx_o == IDX_W'(g + 1)))
            |=> flags_o[g]);
      end
   end

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
   .NSRC       (NSRC),
   .LEVEL_MASK (LEVEL_MASK),
   .IDX_W      (IDX_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flag_clr_i (flag_clr_i),
   .reti_i     (reti_i),
   .ack_i      (ack_i),
   .irq_o      (irq_o),
   .vec_idx_o  (vec_idx_o),
   .flags_o    (flags_o),
   .gie_o      (gie_o)
);

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;

   localparam int unsigned NSRC  = 8;
   localparam int unsigned AW    = 16;
   localparam int unsigned IW    = 4;
   localparam logic [7:0]  LVL   = 8'hC0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    evt = '0, en_wdata = '0, flag_clr = '0;
   logic          en_wr = 0, gie_set = 0, gie_clr = 0, reti = 0, insn_done = 0, reloc = 0, ack = 0;
   logic          irq;
   logic [IW-1:0] vidx;
   logic [AW-1:0] vaddr;
   logic [7:0]    flags;
   logic          gie;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   irq_vec_ctrl #(
      .NSRC(NSRC), .ADDR_W(AW), .BOOT_BASE(32'h3800), .LEVEL_MASK(64'h0000_0000_0000_00C0)
   ) i_irq_vec_ctrl (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .en_wr_i(en_wr), .en_wdata_i(en_wdata),
      .flag_clr_i(flag_clr), .gie_set_i(gie_set), .gie_clr_i(gie_clr), .reti_i(reti),
      .insn_done_i(insn_done), .reloc_i(reloc), .ack_i(ack), .irq_o(irq),
      .vec_idx_o(vidx), .vec_addr_o(vaddr), .flags_o(flags), .gie_o(gie)
   );

   // Fields: en[37:30] ev[29:22] reloc[21] irq[20] idx[19:16] addr[15:0]
   localparam logic [37:0] VEC [8] = '{
      {8'hFF, 8'h01, 1'b0, 1'b1, 4'd1, 16'h0002},
      {8'hFF, 8'h0A, 1'b0, 1'b1, 4'd2, 16'h0004},
      {8'hF0, 8'h0F, 1'b0, 1'b0, 4'd0, 16'h0000},
      {8'hFF, 8'h30, 1'b1, 1'b1, 4'd5, 16'h380A},
      {8'h40, 8'h40, 1'b0, 1'b1, 4'd7, 16'h000E},
      {8'hC0, 8'hC1, 1'b1, 1'b1, 4'd7, 16'h380E},
      {8'h80, 8'h80, 1'b0, 1'b1, 4'd8, 16'h0010},
      {8'h00, 8'hFF, 1'b0, 1'b0, 4'd0, 16'h0000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic scrub();
      evt = '0; flag_clr = 8'hFF; gie_clr = 1; en_wr = 1; en_wdata = '0; reloc = 0;
      step();
      flag_clr = '0; gie_clr = 0; en_wr = 0;
   endtask

   task automatic set_en(input logic [7:0] v);
      en_wr = 1; en_wdata = v; step(); en_wr = 0;
   endtask

   task automatic pulse(input logic [7:0] v);
      evt = v; step(); evt = '0;
   endtask

   task automatic take();
      ack = 1; step(); ack = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 irq", irq, 0); check("R1 flags", flags, 0); check("R1 gie", gie, 0);
      rst_n = 1;
      step();
      check("R1 irq after release", irq, 0);

      // Table walk: R5 R6 R7 R4
      for (int k = 0; k < 8; k++) begin
         scrub();
         reloc = VEC[k][21];
         set_en(VEC[k][37:30]);
         evt = VEC[k][29:22];
         step();
         evt = VEC[k][29:22] & LVL;
         gie_set = 1; step(); gie_set = 0;
         check("R5 table irq", irq, VEC[k][20]);
         if (VEC[k][20]) begin
            check("R6 table idx", vidx, VEC[k][19:16]);
            check("R7 table addr", vaddr, VEC[k][15:0]);
         end
         evt = '0;
      end

      // R2 event latched while masked
      scrub();
      pulse(8'h04);
      check("R2 flag set while masked", flags, 8'h04);
      check("R2 no irq while masked", irq, 0);
      step();
      check("R2 flag sticky", flags, 8'h04);
      set_en(8'hFF); gie_set = 1; step(); gie_set = 0;
      check("R2 later taken idx", vidx, 3);
      check("R10 gie set raises irq", irq, 1);
      gie_clr = 1; step(); gie_clr = 0;
      check("R10 gie clear drops irq", irq, 0);

      // R3 software clear, event wins over clear
      flag_clr = 8'h04; step(); flag_clr = '0;
      check("R3 w1c clears", flags, 8'h00);
      evt = 8'h08; flag_clr = 8'h08; step(); evt = '0; flag_clr = '0;
      check("R3 event beats clear", flags, 8'h08);

      // R8 acceptance clears the flag and global enable
      gie_set = 1; step(); gie_set = 0;
      check("R8 pre irq", irq, 1);
      take();
      check("R8 flag cleared", flags, 8'h00);
      check("R8 gie cleared", gie, 0);
      check("R8 irq low", irq, 0);

      // R4 level condition gone before enable
      scrub();
      pulse(8'h40);
      check("R4 level not flagged", flags, 8'h00);
      set_en(8'hFF); gie_set = 1; step(); gie_set = 0;
      check("R4 gone level no irq", irq, 0);

      // R11 served in priority order
      scrub();
      pulse(8'h12);
      set_en(8'hFF); gie_set = 1; step(); gie_set = 0;
      check("R11 first idx", vidx, 2);
      take();
      check("R11 after first flags", flags, 8'h10);
      gie_set = 1; step(); gie_set = 0;
      check("R11 second idx", vidx, 5);
      take();
      // R10 nesting: event during handler, then re-enable
      pulse(8'h01);
      check("R10 held by gie off", irq, 0);
      gie_set = 1; step(); gie_set = 0;
      check("R10 nested irq", irq, 1);
      check("R10 nested idx", vidx, 1);
      take();

      // R9 one instruction after return
      scrub();
      set_en(8'hFF);
      pulse(8'h01);
      reti = 1; step(); reti = 0;
      check("R9 gie set by reti", gie, 1);
      check("R9 held after reti", irq, 0);
      step();
      check("R9 still held", irq, 0);
      insn_done = 1; step(); insn_done = 0;
      check("R9 released", irq, 1);
      check("R9 released idx", vidx, 1);
      take();
      pulse(8'h02);
      reti = 1; insn_done = 1; step(); reti = 0; insn_done = 0;
      check("R9 same-cycle insn ignored", irq, 0);
      insn_done = 1; step(); insn_done = 0;
      check("R9 release idx", vidx, 2);
      check("R9 release irq", irq, 1);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule